// File: doc/BRIEF.md
# Time-to-digital converter event readout controller

This block sequences the readout of one event from a multi-channel time-to-digital converter. A timing or no-timing trigger starts it. In triggered mode it then lets a programmable window run out, so that late hits can still reach the channel buffers. In trigger-less mode it skips that wait. It writes a header word that carries the trigger's random code. It then takes a snapshot of the channel buffers that hold data and empties them one at a time, lowest channel index first. Each buffer word is copied into the endpoint output stream.

Once every buffer is empty, the controller waits for the level-1 validation of the trigger and classifies the outcome. It keeps saturating counts of three events: triggers that arrive while a readout is in progress, timing validations of events that were started without timing, and readouts of timing-started events that were not validated as timing. Status words that report these counts are appended for trigger type 0xE, or always when debug is enabled. The controller then pulses the trigger release and rests one cycle before it accepts the next trigger. The current state is always visible as an 8-bit hex code for a logic analyser.

Top module: `tdc_rdo_ctrl`

## Requirements
- R1: During and directly after reset, `dbg_state_o` is 0x01, all three counters are zero, and `out_wr_o`, `ch_rd_o` and `trg_release_o` are inactive.
- R2: `dbg_state_o` shows the state code: 0x01 idle, 0x02 window wait, 0x03 header, 0x04/0x05 channel choice, 0x06 mask check, 0x07/0x08/0x09 channel read, 0x0A/0x0B/0x0C validation, 0x0D status, 0x0E/0x0F release. Every code is reachable.
- R3: When `cfg_trig_mode_i`=1, the header is written W+2 cycles after the cycle in which the trigger is sampled, where W = `cfg_window_i` and W = 0 is allowed. When `cfg_trig_mode_i`=0, the header follows one cycle after that cycle and the window state is never entered.
- R4: The header word has bits [31:29]=001, bits [7:0] equal to the `trg_code_i` value sampled with the starting trigger, and all other bits zero.
- R5: Only channels whose `ch_has_data_i` bit is set when the header is written are read. They are read in ascending index order, and at most one `ch_rd_o` bit is high in any cycle. The read pulse is given in state 0x07. The word is taken from `ch_data_i` (channel c at bits [32c+31:32c]) two cycles later, in state 0x09, and written out unchanged.
- R6: A channel is read repeatedly until its `ch_empty_i` bit, sampled in state 0x09, is high. Every stored word appears exactly once, in buffer order.
- R7: In state 0x0A the controller stays put until one of `val_timing_i`, `val_notiming_i` or `val_invalid_i` is high. If more than one is high, timing takes priority over no-timing, and no-timing over invalid. `val_type_i` is sampled together with that validation.
- R8: Exactly three status words follow the channel data when the sampled type is 0xE or `cfg_debug_i`=1, and none otherwise. Each status word has [31:29]=011, [25:24] = index (0 multi-trigger, 1 spurious, 2 wrong readout), and [23:0] = that counter, zero-extended.
- R9: `trg_release_o` is high for exactly one cycle per event, in state 0x0E. It is followed by one cycle in 0x0F and then by idle.
- R10: `cnt_multi_o` increments for every cycle, outside idle, in which `trg_timing_i` or `trg_notiming_i` is high. Such triggers do not restart the readout.
- R11: `cnt_spurious_o` increments when an event started by `trg_notiming_i` is validated as timing.
- R12: `cnt_wrong_o` increments when an event started by `trg_timing_i` is validated as no-timing or invalid.
- R13: All three counters saturate at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trig_mode_i | input | 1 | 1 triggered mode with window, 0 trigger-less |
| cfg_debug_i | input | 1 | Append status words after every event |
| cfg_window_i | input | WIN_W | Post-trigger window length in clock cycles |
| trg_timing_i | input | 1 | Timing trigger pulse |
| trg_notiming_i | input | 1 | No-timing trigger pulse |
| trg_code_i | input | 8 | Trigger random code, sampled at start |
| val_timing_i | input | 1 | Level-1 validation: timing trigger |
| val_notiming_i | input | 1 | Level-1 validation: no-timing trigger |
| val_invalid_i | input | 1 | Level-1 validation: invalid trigger |
| val_type_i | input | 4 | Trigger type accompanying validation |
| ch_has_data_i | input | NUM_CH | Per-channel buffer holds data |
| ch_empty_i | input | NUM_CH | Per-channel buffer empty after last read |
| ch_data_i | input | 32*NUM_CH | Per-channel read data, one cycle after read |
| ch_rd_o | output | NUM_CH | Per-channel read strobe |
| out_wr_o | output | 1 | Endpoint buffer write strobe |
| out_data_o | output | 32 | Endpoint buffer write data |
| trg_release_o | output | 1 | Trigger release pulse |
| dbg_state_o | output | 8 | Hex-coded current state |
| cnt_multi_o | output | CNT_W | Triggers received during readout |
| cnt_spurious_o | output | CNT_W | Spurious timing validations |
| cnt_wrong_o | output | CNT_W | Wrong readouts |

## Verification
The bench builds the block with NUM_CH=3, WIN_W=4 and CNT_W=4. With three channels, all 27 combinations of zero, one or two stored words per channel can be swept. Across those events the window length, the mode, the starting trigger kind, the validation kind and the status gating all rotate arithmetically. The four-bit counters are small enough that saturation of the multi-trigger count is reached within the sweep.

// File: rtl/tdc_rdo_pkg.sv
package tdc_rdo_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [7:0] {
        ST_IDLE   = 8'h01,
        ST_WIN    = 8'h02,
        ST_HDR    = 8'h03,
        ST_PICK_A = 8'h04,
        ST_PICK_B = 8'h05,
        ST_MASK   = 8'h06,
        ST_RD_A   = 8'h07,
        ST_RD_B   = 8'h08,
        ST_RD_C   = 8'h09,
        ST_VAL_A  = 8'h0A,
        ST_VAL_B  = 8'h0B,
        ST_VAL_C  = 8'h0C,
        ST_STAT   = 8'h0D,
        ST_REL_A  = 8'h0E,
        ST_REL_B  = 8'h0F
    } rdo_state_e;

    typedef enum logic [1:0] {
        VK_NONE     = 2'd0,
        VK_TIMING   = 2'd1,
        VK_NOTIMING = 2'd2,
        VK_INVALID  = 2'd3
    } val_kind_e;

    localparam logic [2:0] HDR_TAG   = 3'b001;
    localparam logic [2:0] STAT_TAG  = 3'b011;
    localparam logic [3:0] STAT_TYPE = 4'hE;
    localparam logic [1:0] STAT_LAST = 2'd2;

endpackage

// File: rtl/tdc_rdo_chan_pick.sv
module tdc_rdo_chan_pick #(
    parameter int NUM_CH = 8,
    parameter int SEL_W  = 3
) (
    input  logic [NUM_CH-1:0] mask_i,
    output logic [SEL_W-1:0]  idx_o,
    output logic              any_o
);

    always_comb begin
        idx_o = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = SEL_W'(i);
            end
        end
        any_o = |mask_i;
    end

endmodule

// File: rtl/tdc_rdo_evcnt.sv
module tdc_rdo_evcnt #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != {W{1'b1}})) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/tdc_rdo_ctrl.sv
module tdc_rdo_ctrl
    import tdc_rdo_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int WIN_W  = 11,
    parameter int CNT_W  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_trig_mode_i,
    input  logic                     cfg_debug_i,
    input  logic [WIN_W-1:0]         cfg_window_i,
    input  logic                     trg_timing_i,
    input  logic                     trg_notiming_i,
    input  logic [7:0]               trg_code_i,
    input  logic                     val_timing_i,
    input  logic                     val_notiming_i,
    input  logic                     val_invalid_i,
    input  logic [3:0]               val_type_i,
    input  logic [NUM_CH-1:0]        ch_has_data_i,
    input  logic [NUM_CH-1:0]        ch_empty_i,
    input  logic [NUM_CH*WORD_W-1:0] ch_data_i,
    output logic [NUM_CH-1:0]        ch_rd_o,
    output logic                     out_wr_o,
    output logic [WORD_W-1:0]        out_data_o,
    output logic                     trg_release_o,
    output logic [7:0]               dbg_state_o,
    output logic [CNT_W-1:0]         cnt_multi_o,
    output logic [CNT_W-1:0]         cnt_spurious_o,
    output logic [CNT_W-1:0]         cnt_wrong_o
);

    localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NUM_EV = 3;
    localparam int EV_MULTI = 0;
    localparam int EV_SPUR  = 1;
    localparam int EV_WRONG = 2;

    typedef struct packed {
        rdo_state_e        state;
        logic [WIN_W-1:0]  win;
        logic [NUM_CH-1:0] mask;
        logic [SEL_W-1:0]  sel;
        logic [7:0]        code;
        logic [3:0]        vtype;
        logic              by_timing;
        val_kind_e         vkind;
        logic [1:0]        sidx;
    } regs_t;

    regs_t d, q;

    logic [WORD_W-1:0] ch_word [NUM_CH];
    logic [SEL_W-1:0]  pick_idx;
    logic              pick_any;
    logic [NUM_EV-1:0] ev_inc;
    logic [CNT_W-1:0]  ev_cnt [NUM_EV];
    logic [CNT_W-1:0]  stat_val;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_word
        assign ch_word[g] = ch_data_i[g*WORD_W +: WORD_W];
    end

    tdc_rdo_chan_pick #(
        .NUM_CH (NUM_CH),
        .SEL_W  (SEL_W)
    ) u_pick (
        .mask_i (q.mask),
        .idx_o  (pick_idx),
        .any_o  (pick_any)
    );

    for (genvar g = 0; g < NUM_EV; g++) begin : g_evcnt
        tdc_rdo_evcnt #(
            .W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (ev_inc[g]),
            .cnt_o (ev_cnt[g])
        );
    end

    always_comb begin
        case (q.sidx)
            2'd0:    stat_val = ev_cnt[EV_MULTI];
            2'd1:    stat_val = ev_cnt[EV_SPUR];
            default: stat_val = ev_cnt[EV_WRONG];
        endcase
    end

    always_comb begin
        d             = q;
        ch_rd_o       = '0;
        out_wr_o      = 1'b0;
        out_data_o    = '0;
        trg_release_o = 1'b0;
        ev_inc        = '0;

        if (q.state != ST_IDLE) begin
            ev_inc[EV_MULTI] = trg_timing_i | trg_notiming_i;
        end

        case (q.state)
            ST_IDLE: begin
                if (trg_timing_i || trg_notiming_i) begin
                    d.by_timing = trg_timing_i;
                    d.code      = trg_code_i;
                    d.win       = cfg_window_i;
                    d.vkind     = VK_NONE;
                    d.state     = cfg_trig_mode_i ? ST_WIN : ST_HDR;
                end
            end
            ST_WIN: begin
                if (q.win == '0) begin
                    d.state = ST_HDR;
                end else begin
                    d.win = q.win - 1'b1;
                end
            end
            ST_HDR: begin
                out_wr_o   = 1'b1;
                out_data_o = {HDR_TAG, 21'd0, q.code};
                d.mask     = ch_has_data_i;
                d.state    = ST_PICK_A;
            end
            ST_PICK_A: begin
                d.sel   = pick_idx;
                d.state = ST_PICK_B;
            end
            ST_PICK_B: begin
                d.state = ST_MASK;
            end
            ST_MASK: begin
                d.state = pick_any ? ST_RD_A : ST_VAL_A;
            end
            ST_RD_A: begin
                ch_rd_o[q.sel] = 1'b1;
                d.state        = ST_RD_B;
            end
            ST_RD_B: begin
                d.state = ST_RD_C;
            end
            ST_RD_C: begin
                out_wr_o   = 1'b1;
                out_data_o = ch_word[q.sel];
                if (ch_empty_i[q.sel]) begin
                    d.mask[q.sel] = 1'b0;
                    d.state       = ST_PICK_A;
                end else begin
                    d.state = ST_RD_A;
                end
            end
            ST_VAL_A: begin
                d.vtype = val_type_i;
                if (val_timing_i) begin
                    d.vkind = VK_TIMING;
                    d.state = ST_VAL_B;
                end else if (val_notiming_i) begin
                    d.vkind = VK_NOTIMING;
                    d.state = ST_VAL_B;
                end else if (val_invalid_i) begin
                    d.vkind = VK_INVALID;
                    d.state = ST_VAL_B;
                end else begin
                    d.vtype = q.vtype;
                end
            end
            ST_VAL_B: begin
                ev_inc[EV_SPUR]  = (q.vkind == VK_TIMING) && !q.by_timing;
                ev_inc[EV_WRONG] = (q.vkind != VK_TIMING) && q.by_timing;
                d.state          = ST_VAL_C;
            end
            ST_VAL_C: begin
                d.sidx = '0;
                if ((q.vtype == STAT_TYPE) || cfg_debug_i) begin
                    d.state = ST_STAT;
                end else begin
                    d.state = ST_REL_A;
                end
            end
            ST_STAT: begin
                out_wr_o   = 1'b1;
                out_data_o = {STAT_TAG, 3'd0, q.sidx, 24'(stat_val)};
                if (q.sidx == STAT_LAST) begin
                    d.state = ST_REL_A;
                end else begin
                    d.sidx = q.sidx + 1'b1;
                end
            end
            ST_REL_A: begin
                trg_release_o = 1'b1;
                d.state       = ST_REL_B;
            end
            ST_REL_B: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state     <= ST_IDLE;
            q.win       <= '0;
            q.mask      <= '0;
            q.sel       <= '0;
            q.code      <= '0;
            q.vtype     <= '0;
            q.by_timing <= 1'b0;
            q.vkind     <= VK_NONE;
            q.sidx      <= '0;
        end else begin
            q <= d;
        end
    end

    assign dbg_state_o    = q.state;
    assign cnt_multi_o    = ev_cnt[EV_MULTI];
    assign cnt_spurious_o = ev_cnt[EV_SPUR];
    assign cnt_wrong_o    = ev_cnt[EV_WRONG];

endmodule

// File: rtl/tdc_rdo_ctrl_chk.sv
module tdc_rdo_ctrl_chk #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_trig_mode_i,
    input logic              val_timing_i,
    input logic              val_notiming_i,
    input logic              val_invalid_i,
    input logic [NUM_CH-1:0] ch_rd_o,
    input logic              out_wr_o,
    input logic [31:0]       out_data_o,
    input logic              trg_release_o,
    input logic [7:0]        dbg_state_o,
    input logic [CNT_W-1:0]  cnt_multi_o,
    input logic [CNT_W-1:0]  cnt_spurious_o,
    input logic [CNT_W-1:0]  cnt_wrong_o
);

    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rd_o)); // R5
    AST_RD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_rd_o) |-> (dbg_state_o == 8'h07)); // R5
    AST_HDR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state_o == 8'h03) |-> (out_wr_o && out_data_o[31:29] == 3'b001)); // R4
    AST_STAT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state_o == 8'h0D) |-> (out_wr_o && out_data_o[31:29] == 3'b011)); // R8
    AST_WIN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state_o == 8'h02) |-> cfg_trig_mode_i); // R3
    AST_VAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state_o == 8'h0A && !val_timing_i && !val_notiming_i && !val_invalid_i)
        |=> (dbg_state_o == 8'h0A)); // R7
    AST_REL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trg_release_o |=> (dbg_state_o == 8'h0F && !trg_release_o)); // R9
    AST_REL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_state_o == 8'h0F) |=> (dbg_state_o == 8'h01)); // R9
    AST_MULTI_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_multi_o >= $past(cnt_multi_o)); // R10
    AST_SPUR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_spurious_o >= $past(cnt_spurious_o)); // R11
    AST_WRONG_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wrong_o >= $past(cnt_wrong_o)); // R12

endmodule

bind tdc_rdo_ctrl tdc_rdo_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_trig_mode_i (cfg_trig_mode_i),
    .val_timing_i    (val_timing_i),
    .val_notiming_i  (val_notiming_i),
    .val_invalid_i   (val_invalid_i),
    .ch_rd_o         (ch_rd_o),
    .out_wr_o        (out_wr_o),
    .out_data_o      (out_data_o),
    .trg_release_o   (trg_release_o),
    .dbg_state_o     (dbg_state_o),
    .cnt_multi_o     (cnt_multi_o),
    .cnt_spurious_o  (cnt_spurious_o),
    .cnt_wrong_o     (cnt_wrong_o)
);

// File: tb/tdc_rdo_ctrl_bench.sv
module tdc_rdo_ctrl_bench;

    localparam int NCH = 3;
    localparam int WW  = 4;
    localparam int CW  = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_trig_mode = 1'b1;
    logic            cfg_debug = 1'b0;
    logic [WW-1:0]   cfg_window = '0;
    logic            trg_timing = 1'b0;
    logic            trg_notiming = 1'b0;
    logic [7:0]      trg_code = '0;
    logic            val_timing = 1'b0;
    logic            val_notiming = 1'b0;
    logic            val_invalid = 1'b0;
    logic [3:0]      val_type = '0;
    logic [NCH-1:0]  ch_has_data;
    logic [NCH-1:0]  ch_empty;
    logic [NCH*32-1:0] ch_data;
    logic [NCH-1:0]  ch_rd;
    logic            out_wr;
    logic [31:0]     out_data;
    logic            trg_release;
    logic [7:0]      dbg_state;
    logic [CW-1:0]   cnt_multi, cnt_spur, cnt_wrong;

    int n_chk = 0;
    int n_fail = 0;

    int          fifo_len [NCH];
    int          fifo_idx [NCH];
    logic [31:0] fifo_dat [NCH];
    logic        fifo_load = 1'b0;

    logic [31:0] log_w [512];
    int          log_n = 0;
    int          rel_n = 0;
    int          rd_n  = 0;
    logic [15:0] seen  = '0;

    always #4 clk = ~clk;

    tdc_rdo_ctrl #(.NUM_CH(NCH), .WIN_W(WW), .CNT_W(CW)) u_tdc_rdo_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_trig_mode_i(cfg_trig_mode), .cfg_debug_i(cfg_debug),
        .cfg_window_i(cfg_window),
        .trg_timing_i(trg_timing), .trg_notiming_i(trg_notiming),
        .trg_code_i(trg_code),
        .val_timing_i(val_timing), .val_notiming_i(val_notiming),
        .val_invalid_i(val_invalid), .val_type_i(val_type),
        .ch_has_data_i(ch_has_data), .ch_empty_i(ch_empty),
        .ch_data_i(ch_data), .ch_rd_o(ch_rd),
        .out_wr_o(out_wr), .out_data_o(out_data),
        .trg_release_o(trg_release), .dbg_state_o(dbg_state),
        .cnt_multi_o(cnt_multi), .cnt_spurious_o(cnt_spur),
        .cnt_wrong_o(cnt_wrong)
    );

    function automatic logic [31:0] chw(int c, int i);
        return 32'hA000_0000 | (c << 8) | i;
    endfunction

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ch_has_data[c]      = (fifo_len[c] != 0);
            ch_empty[c]         = (fifo_idx[c] >= fifo_len[c]);
            ch_data[c*32 +: 32] = fifo_dat[c];
        end
    end

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (fifo_load) begin
                fifo_idx[c] <= 0;
                fifo_dat[c] <= '0;
            end else if (ch_rd[c]) begin
                fifo_dat[c] <= chw(c, fifo_idx[c]);
                fifo_idx[c] <= fifo_idx[c] + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_wr) begin
                log_w[log_n] = out_data;
                log_n = log_n + 1;
            end
            if (trg_release) rel_n = rel_n + 1;
            rd_n = rd_n + $countones(ch_rd);
            if (dbg_state < 8'd16) seen[dbg_state[3:0]] = 1'b1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int sat(int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    int exp_multi = 0, exp_spur = 0, exp_wrong = 0;

    task automatic run_event(int e);
        int lens [NCH];
        int base, k, w, en, vk;
        logic mode, by_t, stat;
        logic [3:0] vt;
        logic [31:0] exp_log [16];
        lens[0] = e % 3; lens[1] = (e / 3) % 3; lens[2] = e / 9;
        mode = (e % 4) != 3;
        w    = e % 5;
        by_t = (e % 2) == 0;
        vk   = e % 3;
        vt   = (e % 5 == 1) ? 4'hE : 4'h1;
        cfg_debug     = (e % 7 == 3);
        cfg_trig_mode = mode;
        cfg_window    = WW'(w);
        trg_code      = 8'(e * 37 + 5);
        for (int c = 0; c < NCH; c++) fifo_len[c] = lens[c];
        fifo_load = 1'b1;
        @(negedge clk);
        fifo_load = 1'b0;
        base = log_n;
        if (by_t) trg_timing = 1'b1; else trg_notiming = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            trg_timing = 1'b0; trg_notiming = 1'b0;
            k++;
        end while (dbg_state != 8'h03 && k < 40);
        check(mode ? "R3 header latency triggered" : "R3 header latency trigger-less",
              32'(k), mode ? 32'(w + 2) : 32'd1);
        k = 0;
        while (dbg_state != 8'h0A && k < 200) begin @(negedge clk); k++; end
        if (e % 3 != 2) begin
            trg_timing = 1'b1;  // R10 trigger during readout
            @(negedge clk);
            trg_timing = 1'b0;
            exp_multi = sat(exp_multi + 1);
        end
        repeat (3) @(negedge clk);
        check("R7 wait for validation", 32'(dbg_state), 32'h0A);
        val_type = vt;
        if (vk == 0) val_timing = 1'b1;
        else if (vk == 1) val_notiming = 1'b1;
        else val_invalid = 1'b1;
        @(negedge clk);
        val_timing = 1'b0; val_notiming = 1'b0; val_invalid = 1'b0;
        if (vk == 0 && !by_t) exp_spur = sat(exp_spur + 1);
        if (vk != 0 && by_t)  exp_wrong = sat(exp_wrong + 1);
        k = 0;
        while (dbg_state != 8'h01 && k < 40) begin @(negedge clk); k++; end
        en = 0;
        exp_log[en++] = {3'b001, 21'd0, 8'(e * 37 + 5)};
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < lens[c]; i++) exp_log[en++] = chw(c, i);
        stat = (vt == 4'hE) || cfg_debug;
        if (stat) begin
            exp_log[en++] = {3'b011, 3'd0, 2'd0, 24'(exp_multi)};
            exp_log[en++] = {3'b011, 3'd0, 2'd1, 24'(exp_spur)};
            exp_log[en++] = {3'b011, 3'd0, 2'd2, 24'(exp_wrong)};
        end
        check("R8 word count per event", 32'(log_n - base), 32'(en));
        check("R4 header word", log_w[base], exp_log[0]);
        for (int i = 1; i < en; i++)
            check(i <= lens[0] + lens[1] + lens[2] ? "R5 R6 channel word" : "R8 status word",
                  log_w[base + i], exp_log[i]);
        check("R9 one release per event", 32'(rel_n), 32'(e + 1));
        check("R10 multi count", 32'(cnt_multi), 32'(exp_multi));
        check("R11 spurious count", 32'(cnt_spur), 32'(exp_spur));
        check("R12 wrong readout count", 32'(cnt_wrong), 32'(exp_wrong));
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) fifo_len[c] = 0;
        repeat (3) @(negedge clk);
        check("R1 reset state code", 32'(dbg_state), 32'h01);
        check("R1 reset strobes", {29'd0, out_wr, trg_release, |ch_rd}, 32'd0);
        check("R1 reset counters", {20'd0, cnt_multi, cnt_spur, cnt_wrong}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 32'(dbg_state), 32'h01);
        for (int e = 0; e < 27; e++) run_event(e);
        check("R5 total read strobes", 32'(rd_n), 32'd81);
        check("R2 every state code seen", {16'd0, seen}, 32'h0000_FFFE);
        check("R13 multi counter saturated", 32'(cnt_multi), 32'(CMAX));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule